// File: doc/BRIEF.md
# Calendar Ordinal Day Encoder

This block turns a calendar date into an ordinal day of the year. It takes a binary month code, a day of month and a leap-year flag. From these it produces two results. The first is a one-hot indication of how many days the month holds. The second is the running day count from the first of January. It also flags any date that cannot exist.

The leap flag acts inside the month-offset lookup. The adder behind that lookup therefore only sums an offset and a day. The leap flag itself comes from outside the block.

An output register stage is selected by a parameter, and it is on by default. It captures a result on every cycle where `in_valid` is high and presents it one cycle later with `out_valid`. There is no ready input and no back-pressure. The block accepts a date on every cycle. A consumer that cannot keep up must gate `in_valid` upstream. On cycles with `in_valid` low, the registered results hold and `out_valid` is low. With the register disabled, the outputs follow the inputs combinationally and `out_valid` equals `in_valid`.

Top module: `cal_ordinal_enc`

## Requirements
- R1: The month-length output `len_onehot` has bit 0 = 28 days, bit 1 = 29 days, bit 2 = 30 days and bit 3 = 31 days. For February (code 2) it is bit 1 when `leap` is 1 and bit 0 when `leap` is 0.
- R2: Months 4, 6, 9 and 11 give bit 2 (30 days). Months 1, 3, 5, 7, 8, 10 and 12 give bit 3 (31 days).
- R3: Month codes 0 and 13 to 15 give `len_onehot` = 0000 and raise `date_err`.
- R4: For a valid date, `doy` = month offset + day. The common-year offsets are 0, 31, 59, 90, 120, 151, 181, 212, 243, 273, 304 and 334 for months 1 to 12. When `leap` is 1, one is added to the offset of every month from 3 onward.
- R5: A day of 0, or a day greater than the decoded month length, raises `date_err`.
- R6: While `date_err` is high, `doy` is 0. While it is low, `doy` lies in 1 to 366.
- R7: With the register stage enabled, a date presented with `in_valid` high appears on the outputs one cycle later with `out_valid` high. When `in_valid` is low, `out_valid` goes low the next cycle and the data outputs keep their values.
- R8: Synchronous reset (`rst` high at a rising edge) clears `out_valid`, `len_onehot`, `doy` and `date_err` to 0.
- R9: December 31 gives `doy` 365 in a common year and 366 in a leap year.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A date is present on the inputs |
| month | input | 4 | Month code, 1 to 12 valid |
| day | input | 5 | Day of month |
| leap | input | 1 | The year is a leap year |
| out_valid | output | 1 | Results on the outputs belong to an accepted date |
| len_onehot | output | 4 | One-hot month length (28/29/30/31 days) |
| doy | output | 9 | Ordinal day of the year, 0 on error |
| date_err | output | 1 | Date is invalid |

## Verification
Some properties are checked on every cycle:
- the month length is never more than one-hot;
- an empty length always comes with an error;
- an error always forces the ordinal day to zero;
- a valid result stays within 1 to 366;
- the one-cycle valid delay and the hold of data on idle cycles.

Other behaviour only shows up in the bench's scenarios: the exact offset for each month, the leap adjustment from March onward, and the month-end limits. These need known dates with worked-out answers, which the vector table and the directed reset and hold cases supply.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int LEN_W = 4;

  typedef enum logic [1:0] {
    LEN_28 = 2'd0,
    LEN_29 = 2'd1,
    LEN_30 = 2'd2,
    LEN_31 = 2'd3
  } len_idx_e;

  // Number of days in month m; 0 for codes outside 1..12.
  function automatic int month_days(input int m, input bit lp);
    case (m)
      1, 3, 5, 7, 8, 10, 12: return 31;
      4, 6, 9, 11:           return 30;
      2:                     return lp ? 29 : 28;
      default:               return 0;
    endcase
  endfunction

  // Days elapsed before the first of month m; 0 for invalid codes.
  function automatic int cum_offset(input int m, input bit lp);
    int acc;
    acc = 0;
    if (m >= 1 && m <= 12) begin
      for (int i = 1; i < m; i++) acc += month_days(i, lp);
    end
    return acc;
  endfunction

endpackage

// File: rtl/cal_len_decode.sv
module cal_len_decode
  import cal_pkg::*;
#(
  parameter int MONTH_W = 4
) (
  input  logic [MONTH_W-1:0] month,
  input  logic               leap,
  output logic [LEN_W-1:0]   len_onehot
);

  always_comb begin
    len_onehot = '0;
    case (month)
      MONTH_W'(2): begin
        if (leap) len_onehot[LEN_29] = 1'b1;
        else      len_onehot[LEN_28] = 1'b1;
      end
      MONTH_W'(4), MONTH_W'(6), MONTH_W'(9), MONTH_W'(11):
        len_onehot[LEN_30] = 1'b1;
      MONTH_W'(1), MONTH_W'(3), MONTH_W'(5), MONTH_W'(7),
      MONTH_W'(8), MONTH_W'(10), MONTH_W'(12):
        len_onehot[LEN_31] = 1'b1;
      default: len_onehot = '0;
    endcase
  end

endmodule

// File: rtl/cal_offset_lut.sv
module cal_offset_lut
  import cal_pkg::*;
#(
  parameter int MONTH_W = 4,
  parameter int DOY_W   = 9
) (
  input  logic [MONTH_W-1:0] month,
  input  logic               leap,
  output logic [DOY_W-1:0]   offset
);

  localparam int CODES = 1 << MONTH_W;

  logic [DOY_W-1:0] tab_common [CODES];
  logic [DOY_W-1:0] tab_leap   [CODES];

  // Both tables are constants computed at elaboration time.
  for (genvar k = 0; k < CODES; k++) begin : g_tab
    assign tab_common[k] = DOY_W'(cum_offset(k, 1'b0));
    assign tab_leap[k]   = DOY_W'(cum_offset(k, 1'b1));
  end

  assign offset = leap ? tab_leap[month] : tab_common[month];

endmodule

// File: rtl/cal_date_check.sv
module cal_date_check
  import cal_pkg::*;
#(
  parameter int DAY_W = 5
) (
  input  logic [LEN_W-1:0] len_onehot,
  input  logic [DAY_W-1:0] day,
  output logic             date_err
);

  logic [DAY_W-1:0] day_limit;
  logic             no_month;

  always_comb begin
    day_limit = '0;
    for (int i = 0; i < LEN_W; i++) begin
      if (len_onehot[i]) day_limit = DAY_W'(28 + i);
    end
  end

  assign no_month = (len_onehot == '0);
  assign date_err = no_month || (day == '0) || (day > day_limit);

endmodule

// File: rtl/cal_ordinal_enc.sv
module cal_ordinal_enc
  import cal_pkg::*;
#(
  parameter int MONTH_W = 4,
  parameter int DAY_W   = 5,
  parameter int DOY_W   = 9,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [MONTH_W-1:0] month,
  input  logic [DAY_W-1:0]   day,
  input  logic               leap,
  output logic               out_valid,
  output logic [LEN_W-1:0]   len_onehot,
  output logic [DOY_W-1:0]   doy,
  output logic               date_err
);

  logic [LEN_W-1:0] len_c;
  logic [DOY_W-1:0] offset_c;
  logic [DOY_W-1:0] sum_c;
  logic [DOY_W-1:0] doy_c;
  logic             err_c;

  cal_len_decode #(.MONTH_W(MONTH_W)) u_len (
    .month      (month),
    .leap       (leap),
    .len_onehot (len_c)
  );

  cal_offset_lut #(.MONTH_W(MONTH_W), .DOY_W(DOY_W)) u_off (
    .month  (month),
    .leap   (leap),
    .offset (offset_c)
  );

  cal_date_check #(.DAY_W(DAY_W)) u_chk_date (
    .len_onehot (len_c),
    .day        (day),
    .date_err   (err_c)
  );

  assign sum_c = offset_c + DOY_W'(day);
  assign doy_c = err_c ? '0 : sum_c;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid  <= 1'b0;
        len_onehot <= '0;
        doy        <= '0;
        date_err   <= 1'b0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          len_onehot <= len_c;
          doy        <= doy_c;
          date_err   <= err_c;
        end
      end
    end
  end else begin : g_comb
    assign out_valid  = in_valid;
    assign len_onehot = len_c;
    assign doy        = doy_c;
    assign date_err   = err_c;
  end

endmodule

// File: rtl/cal_ordinal_enc_chk.sv
module cal_ordinal_enc_chk #(
  parameter int DOY_W   = 9,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [3:0]       len_onehot,
  input logic [DOY_W-1:0] doy,
  input logic             date_err
);

  p_len_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0(len_onehot));

  p_nomonth_err_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && len_onehot == 4'b0000) |-> date_err);

  p_err_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && date_err) |-> (doy == '0));

  p_doy_range_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !date_err) |-> (doy >= DOY_W'(1) && doy <= DOY_W'(366)));

  if (REG_OUT) begin : g_seq
    p_valid_delay_r7: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

    p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(doy) && $stable(len_onehot) && $stable(date_err)));
  end

endmodule

bind cal_ordinal_enc cal_ordinal_enc_chk #(
  .DOY_W   (DOY_W),
  .REG_OUT (REG_OUT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .len_onehot (len_onehot),
  .doy        (doy),
  .date_err   (date_err)
);

// File: tb/cal_ordinal_enc_tb.sv
module cal_ordinal_enc_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] month = '0;
  logic [4:0] day = '0;
  logic       leap = 1'b0;
  logic       out_valid;
  logic [3:0] len_onehot;
  logic [8:0] doy;
  logic       date_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cal_ordinal_enc u_dut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .month      (month),
    .day        (day),
    .leap       (leap),
    .out_valid  (out_valid),
    .len_onehot (len_onehot),
    .doy        (doy),
    .date_err   (date_err)
  );

  // Vector: month(4) day(5) leap(1) exp_len(4) exp_doy(9) exp_err(1)
  localparam int NV = 20;
  localparam logic [23:0] VEC [NV] = '{
    {4'd1,  5'd1,  1'b0, 4'b1000, 9'd1,   1'b0},  // R4 R2
    {4'd2,  5'd28, 1'b0, 4'b0001, 9'd59,  1'b0},  // R1
    {4'd2,  5'd29, 1'b0, 4'b0001, 9'd0,   1'b1},  // R5 R6
    {4'd2,  5'd29, 1'b1, 4'b0010, 9'd60,  1'b0},  // R1
    {4'd3,  5'd1,  1'b0, 4'b1000, 9'd60,  1'b0},  // R4
    {4'd3,  5'd1,  1'b1, 4'b1000, 9'd61,  1'b0},  // R4 leap
    {4'd4,  5'd30, 1'b0, 4'b0100, 9'd120, 1'b0},  // R2
    {4'd4,  5'd31, 1'b0, 4'b0100, 9'd0,   1'b1},  // R5
    {4'd6,  5'd15, 1'b1, 4'b0100, 9'd167, 1'b0},  // R2 R4
    {4'd9,  5'd30, 1'b0, 4'b0100, 9'd273, 1'b0},  // R2
    {4'd11, 5'd1,  1'b1, 4'b0100, 9'd306, 1'b0},  // R2 R4
    {4'd12, 5'd31, 1'b0, 4'b1000, 9'd365, 1'b0},  // R9
    {4'd12, 5'd31, 1'b1, 4'b1000, 9'd366, 1'b0},  // R9
    {4'd0,  5'd5,  1'b0, 4'b0000, 9'd0,   1'b1},  // R3
    {4'd13, 5'd1,  1'b0, 4'b0000, 9'd0,   1'b1},  // R3
    {4'd15, 5'd10, 1'b1, 4'b0000, 9'd0,   1'b1},  // R3
    {4'd7,  5'd0,  1'b0, 4'b1000, 9'd0,   1'b1},  // R5
    {4'd8,  5'd31, 1'b1, 4'b1000, 9'd244, 1'b0},  // R4
    {4'd10, 5'd31, 1'b0, 4'b1000, 9'd304, 1'b0},  // R4
    {4'd5,  5'd31, 1'b0, 4'b1000, 9'd151, 1'b0}   // R2 R4
  };

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [8:0] held;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", "out_valid", int'(out_valid), 0);
    check("R8", "len", int'(len_onehot), 0);
    check("R8", "doy", int'(doy), 0);
    check("R8", "err", int'(date_err), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {month, day, leap} = VEC[i][23:14];
      in_valid = 1'b1;
      @(negedge clk);
      check("R7", "out_valid", int'(out_valid), 1);
      check("R1/R2/R3", "len", int'(len_onehot), int'(VEC[i][13:10]));
      check("R4/R6/R9", "doy", int'(doy), int'(VEC[i][9:1]));
      check("R5/R3", "err", int'(date_err), int'(VEC[i][0]));
      in_valid = 1'b0;
    end

    // R7: idle cycle holds data and drops valid
    @(negedge clk);
    month = 4'd3; day = 5'd10; leap = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check("R7", "doy", int'(doy), 69);
    held = doy;
    month = 4'd12; day = 5'd1; in_valid = 1'b0;
    @(negedge clk);
    check("R7", "idle out_valid", int'(out_valid), 0);
    check("R7", "held doy", int'(doy), int'(held));
    check("R7", "held len", int'(len_onehot), 8);

    // R8: reset mid-stream clears registered outputs
    in_valid = 1'b1; month = 4'd12; day = 5'd31; leap = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R8", "out_valid", int'(out_valid), 0);
    check("R8", "doy", int'(doy), 0);
    check("R8", "len", int'(len_onehot), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R9", "doy after reset", int'(doy), 366);
    in_valid = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule